// File: doc/BRIEF.md
# Latched-Address Nibble Register Bus Interface

This block sits between a small microprocessor bus and a clock/calendar core. A host places a 4-bit register number on the address pins, latches it with an address strobe (or ties the strobe high so the pins pass straight through), then moves one 4-bit nibble with an active-low read or write strobe. The part is selected only when a high-active select and a low-active select are both asserted.

There are sixteen nibble registers. Numbers 0x0 to 0xC are the thirteen time digits: units and tens of seconds, minutes, hours, day of month, month and year, then the weekday. The counters behind them live in a separate timekeeping block. This interface reads their current values from a flat input vector and forwards host writes to them as a one-cycle write pulse. Numbers 0xD, 0xE and 0xF are control nibbles held here. Some of their bits have special rules: one bit is read-only, one can only be cleared, and one must stay zero.

Everything runs on one system clock. Reads are combinational from the pins. The write strobe is sampled, and a write commits on its rising edge.

Top module: `nibble_bus_if`

## Requirements
- R1: While `ale` is 1 the effective address equals `addr`, and `addr` is sampled into a latch on each clock edge. While `ale` is 0 the effective address is the value latched at the last edge at which `ale` was 1.
- R2: The block is selected only when `cs1` is 1 and `cs0_n` is 0. When it is not selected, `bus_oe` is 0 and a write strobe has no effect on any register or on `digit_we`.
- R3: `bus_oe` is 1 exactly while the block is selected and `rd_n` is 0. `bus_out` is 0 whenever `bus_oe` is 0.
- R4: A read of address k in 0x0..0xC returns nibble k of `time_q` (bits 4k+3..4k), with nonexistent bits forced to 0. The valid-bit masks are: 0x1, 0x3, 0x5 and 0xC use 4'b0111; 0x7 uses 4'b0011; 0x9 uses 4'b0001; all other digits use 4'b1111. Bit 2 of 0x5 is the PM flag.
- R5: On each clock cycle with `wr_n` low and the block selected, the effective address and `bus_in` are captured. At the first clock edge at which `wr_n` is sampled high again, a capture to 0x0..0xC commits. In the following cycle `digit_we` is 1 for exactly one cycle, `digit_sel` holds the address and `digit_wdata` holds the data ANDed with that address's R4 mask.
- R6: A write commit to 0xD, 0xE or 0xF never raises `digit_we`.
- R7: Register 0xD reads {adjust, irq flag, busy, hold} from bit 3 down to bit 0. A write stores bit 3 into `adj_req` and bit 0 into `hold`. These bits change only on a write commit.
- R8: Bit 1 of 0xD always reads `busy_in`. Writing it has no effect.
- R9: `irq_flag` is set by `irq_set` and cleared only by a write commit to 0xD with bit 2 equal to 0. Writing 1 there has no effect. If `irq_set` and a clearing commit fall on the same edge, the flag ends up set.
- R10: Register 0xF reads {0, mode24, stop, cnt_reset} from bit 3 down to bit 0. Bit 3 always reads 0 whatever was written. Bits 2..0 store the written value.
- R11: Register 0xE stores all four written bits. They read back unchanged and drive `ctl_e`.
- R12: Reset (`rst_n` low) clears every control bit and the latched address, and leaves `digit_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch strobe; 1 = transparent |
| cs0_n | input | 1 | Low-active chip select |
| cs1 | input | 1 | High-active chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 4 | Register number |
| bus_in | input | 4 | Write data from the bus |
| bus_out | output | 4 | Read data to the bus |
| bus_oe | output | 1 | Bus driver enable |
| time_q | input | 52 | Thirteen digit nibbles from the timekeeping core |
| busy_in | input | 1 | Busy status from the core |
| irq_set | input | 1 | Interrupt event from the core |
| digit_we | output | 1 | One-cycle digit write pulse |
| digit_sel | output | 4 | Digit index for the write |
| digit_wdata | output | 4 | Masked digit write data |
| adj_req | output | 1 | Stored adjust bit |
| hold | output | 1 | Stored hold bit |
| irq_flag | output | 1 | Interrupt flag |
| ctl_e | output | 4 | Control nibble 0xE |
| mode24 | output | 1 | 24-hour mode bit |
| stop | output | 1 | Stop bit |
| cnt_reset | output | 1 | Counter reset bit |

## Verification
The two actions that can fall on one clock edge are an interrupt event from the core and a host write that clears the interrupt flag. The bench raises `irq_set` on the same cycle that `wr_n` returns high after a 0xD write with bit 2 at 0. The flag must be 1 both in the per-clock model comparison and in a readback of 0xD. The reference model resolves that edge by set-over-clear, independently of the RTL.

// File: rtl/nibble_bus_if.sv
module nibble_bus_if #(
  parameter int AW   = 4,
  parameter int DW   = 4,
  parameter int NDIG = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ale,
  input  logic               cs0_n,
  input  logic               cs1,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      bus_in,
  output logic [DW-1:0]      bus_out,
  output logic               bus_oe,
  input  logic [NDIG*DW-1:0] time_q,
  input  logic               busy_in,
  input  logic               irq_set,
  output logic               digit_we,
  output logic [AW-1:0]      digit_sel,
  output logic [DW-1:0]      digit_wdata,
  output logic               adj_req,
  output logic               hold,
  output logic               irq_flag,
  output logic [DW-1:0]      ctl_e,
  output logic               mode24,
  output logic               stop,
  output logic               cnt_reset
);
  localparam logic [AW-1:0] REG_D = AW'(NDIG);
  localparam logic [AW-1:0] REG_E = AW'(NDIG + 1);
  localparam logic [AW-1:0] REG_F = AW'(NDIG + 2);

  function automatic logic [DW-1:0] dmask(input logic [AW-1:0] a);
    case (a)
      AW'(1), AW'(3), AW'(5), AW'(12): dmask = DW'(7);
      AW'(7):                          dmask = DW'(3);
      AW'(9):                          dmask = DW'(1);
      default:                         dmask = {DW{1'b1}};
    endcase
  endfunction

  logic [AW-1:0] addr_lat, eff_addr, cap_addr;
  logic [DW-1:0] cap_data, rd_val;
  logic          sel, wr_prev, cap_ok, commit;

  assign eff_addr = ale ? addr : addr_lat;
  assign sel      = cs1 & ~cs0_n;
  assign commit   = cap_ok & wr_n & ~wr_prev;
  assign bus_oe   = sel & ~rd_n;
  assign bus_out  = bus_oe ? rd_val : '0;

  always_comb begin
    if (eff_addr < REG_D)       rd_val = time_q[eff_addr*DW +: DW] & dmask(eff_addr);
    else if (eff_addr == REG_D) rd_val = {adj_req, irq_flag, busy_in, hold};
    else if (eff_addr == REG_E) rd_val = ctl_e;
    else                        rd_val = {1'b0, mode24, stop, cnt_reset};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lat    <= '0;
      wr_prev     <= 1'b1;
      cap_addr    <= '0;
      cap_data    <= '0;
      cap_ok      <= 1'b0;
      digit_we    <= 1'b0;
      digit_sel   <= '0;
      digit_wdata <= '0;
      adj_req     <= 1'b0;
      hold        <= 1'b0;
      irq_flag    <= 1'b0;
      ctl_e       <= '0;
      mode24      <= 1'b0;
      stop        <= 1'b0;
      cnt_reset   <= 1'b0;
    end else begin
      if (ale) addr_lat <= addr;
      wr_prev <= wr_n;
      if (!wr_n) begin
        cap_addr <= eff_addr;
        cap_data <= bus_in;
        cap_ok   <= sel;
      end
      digit_we <= commit && (cap_addr < REG_D);
      if (commit && (cap_addr < REG_D)) begin
        digit_sel   <= cap_addr;
        digit_wdata <= cap_data & dmask(cap_addr);
      end
      if (commit && cap_addr == REG_D) begin
        adj_req <= cap_data[3];
        hold    <= cap_data[0];
      end
      irq_flag <= irq_set | (irq_flag & ~(commit && cap_addr == REG_D && !cap_data[2]));
      if (commit && cap_addr == REG_E) ctl_e <= cap_data;
      if (commit && cap_addr == REG_F) begin
        mode24    <= cap_data[2];
        stop      <= cap_data[1];
        cnt_reset <= cap_data[0];
      end
    end
  end

  assert_unselected_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs1 && !cs0_n) |-> !bus_oe);
  assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    digit_we |=> !digit_we);
  assert_we_digit_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    digit_we |-> (digit_sel < REG_D));
  assert_hold_on_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(hold) && $stable(adj_req)));
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(irq_set));
  assert_test_bit_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && eff_addr == REG_F) |-> !bus_out[3]);
endmodule

// File: tb/nibble_bus_if_tb_top.sv
`timescale 1ns/1ps
module nibble_bus_if_tb_top;
  logic clk = 0, rst_n = 0;
  logic ale = 1, cs0_n = 0, cs1 = 1, rd_n = 1, wr_n = 1, busy_in = 0, irq_set = 0;
  logic [3:0] addr = 0, bus_in = 0;
  logic [51:0] tq = 52'hFFFF_FFFF_FFFF_F;
  logic [3:0] bus_out, digit_sel, digit_wdata, ctl_e;
  logic bus_oe, digit_we, adj_req, hold, irq_flag, mode24, stop, cnt_reset;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  nibble_bus_if dut_i (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs0_n(cs0_n), .cs1(cs1), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .time_q(tq),
    .busy_in(busy_in), .irq_set(irq_set), .digit_we(digit_we), .digit_sel(digit_sel),
    .digit_wdata(digit_wdata), .adj_req(adj_req), .hold(hold), .irq_flag(irq_flag),
    .ctl_e(ctl_e), .mode24(mode24), .stop(stop), .cnt_reset(cnt_reset));

  // reference model state
  int m_lat, m_cap_a, m_cap_d;
  bit m_prev_wr, m_cap_ok, m_we, m_adj, m_hold, m_irq, m_m24, m_stop, m_rst;
  int m_sel_a, m_wd, m_e;

  function automatic int mk(int a);
    case (a)
      1, 3, 5, 12: return 7;
      7: return 3;
      9: return 1;
      default: return 15;
    endcase
  endfunction

  function automatic int rv(int a);
    if (a < 13) return int'((tq >> (a*4)) & 52'hF) & mk(a);
    if (a == 13) return {28'd0, m_adj, m_irq, busy_in, m_hold};
    if (a == 14) return m_e;
    return {29'd0, m_m24, m_stop, m_rst};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat = 0; m_prev_wr = 1; m_cap_ok = 0; m_cap_a = 0; m_cap_d = 0; m_we = 0;
      m_adj = 0; m_hold = 0; m_irq = 0; m_e = 0; m_m24 = 0; m_stop = 0; m_rst = 0;
      m_sel_a = 0; m_wd = 0;
    end else begin
      int eff;
      bit rise, clr;
      eff = ale ? int'(addr) : m_lat;
      if (ale) m_lat = addr;
      rise = wr_n && !m_prev_wr && m_cap_ok;
      m_prev_wr = wr_n;
      m_we = 0; clr = 0;
      if (rise) begin
        if (m_cap_a < 13) begin m_we = 1; m_sel_a = m_cap_a; m_wd = m_cap_d & mk(m_cap_a); end
        else if (m_cap_a == 13) begin m_adj = m_cap_d[3]; m_hold = m_cap_d[0]; clr = !m_cap_d[2]; end
        else if (m_cap_a == 14) m_e = m_cap_d;
        else begin m_m24 = m_cap_d[2]; m_stop = m_cap_d[1]; m_rst = m_cap_d[0]; end
      end
      if (clr) m_irq = 0;
      if (irq_set) m_irq = 1;
      if (!wr_n) begin m_cap_a = eff; m_cap_d = bus_in; m_cap_ok = cs1 && !cs0_n; end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      int eff, eoe, eout;
      eff = ale ? int'(addr) : m_lat;
      eoe = (cs1 && !cs0_n && !rd_n) ? 1 : 0;
      eout = eoe ? rv(eff) : 0;
      chk(int'(bus_oe) == eoe, "R3 bus_oe", bus_oe, eoe);
      chk(int'(bus_out) == eout, "R4 bus_out", bus_out, eout);
      chk(digit_we == m_we, "R5 digit_we", digit_we, m_we);
      if (m_we) chk(int'(digit_sel) == m_sel_a && int'(digit_wdata) == m_wd, "R5 sel/data",
                    {digit_sel, digit_wdata}, {m_sel_a[3:0], m_wd[3:0]});
      chk({adj_req, irq_flag, hold, ctl_e, mode24, stop, cnt_reset} ==
          {m_adj, m_irq, m_hold, m_e[3:0], m_m24, m_stop, m_rst}, "R7 control outputs",
          {adj_req, irq_flag, hold, ctl_e, mode24, stop, cnt_reset},
          {m_adj, m_irq, m_hold, m_e[3:0], m_m24, m_stop, m_rst});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [3:0] d, input bit latch, input bit irq_same);
    @(negedge clk); addr = a; ale = 1;
    @(negedge clk);
    if (latch) begin ale = 0; addr = ~a; end
    bus_in = d; wr_n = 0;
    @(negedge clk);
    @(negedge clk); wr_n = 1; irq_set = irq_same;
    @(posedge clk); #1;
    if (!(cs1 && !cs0_n)) chk(!digit_we, "R2 unselected write", digit_we, 0);
    else if (a < 13) chk(digit_we && digit_sel == a, latch ? "R1 latched write" : "R5 write",
                         digit_sel, a);
    else chk(!digit_we, "R6 control write no pulse", digit_we, 0);
    @(negedge clk); irq_set = 0; ale = 1; addr = a;
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string tag);
    @(negedge clk); addr = a; ale = 1; rd_n = 0;
    #1 chk(int'(bus_out) == exp && bus_oe, tag, bus_out, exp);
    @(negedge clk); rd_n = 1;
  endtask

  initial begin
    #(4*150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({adj_req, irq_flag, hold, ctl_e, mode24, stop, cnt_reset, digit_we} == 0,
        "R12 reset state", {adj_req, irq_flag, hold, ctl_e, mode24, stop, cnt_reset}, 0);
    // digit reads with all-ones pattern: masks visible (R4)
    for (int k = 0; k < 13; k++) rd(k[3:0], mk(k), "R4 digit mask");
    tq = 52'h6_98_12_31_59_59_7;
    for (int k = 0; k < 13; k++) rd(k[3:0], int'((tq >> (k*4)) & 52'hF) & mk(k), "R4 digit value");
    // R1: latched address holds while pins change
    @(negedge clk); addr = 4'd3; ale = 1;
    @(negedge clk); ale = 0; addr = 4'd5; rd_n = 0;
    #1 chk(int'(bus_out) == rv(3), "R1 latched read", bus_out, rv(3));
    @(negedge clk); rd_n = 1; ale = 1;
    // digit writes, transparent and latched, with masking
    wr(4'd1, 4'hF, 0, 0);
    wr(4'd7, 4'hE, 1, 0);
    wr(4'd9, 4'hB, 1, 0);
    wr(4'd12, 4'h9, 0, 0);
    wr(4'd0, 4'h5, 1, 0);
    // R2: unselected accesses
    cs1 = 0; wr(4'd2, 4'h3, 0, 0); cs1 = 1;
    cs0_n = 1; wr(4'hE, 4'hA, 0, 0);
    @(negedge clk); rd_n = 0; #1 chk(!bus_oe && bus_out == 0, "R2 unselected read", bus_oe, 0);
    @(negedge clk); rd_n = 1; cs0_n = 0;
    rd(4'hE, 0, "R2 ignored control write");
    // R11 register E
    wr(4'hE, 4'hA, 0, 0); rd(4'hE, 4'hA, "R11 E readback");
    wr(4'hE, 4'h5, 1, 0); rd(4'hE, 4'h5, "R11 E readback");
    // R10 register F
    wr(4'hF, 4'hF, 0, 0); rd(4'hF, 4'h7, "R10 test bit reads zero");
    wr(4'hF, 4'h4, 0, 0); rd(4'hF, 4'h4, "R10 F fields");
    // R7/R8 register D
    busy_in = 0;
    wr(4'hD, 4'hB, 0, 0); rd(4'hD, 4'h9, "R8 busy not writable");
    busy_in = 1; rd(4'hD, 4'hB, "R8 busy follows input");
    busy_in = 0;
    wr(4'hD, 4'h0, 0, 0); rd(4'hD, 4'h0, "R7 D cleared");
    // R9 irq flag
    @(negedge clk); irq_set = 1; @(negedge clk); irq_set = 0;
    rd(4'hD, 4'h4, "R9 irq set by event");
    wr(4'hD, 4'h4, 0, 0); rd(4'hD, 4'h4, "R9 write one keeps flag");
    wr(4'hD, 4'h0, 0, 0); rd(4'hD, 4'h0, "R9 write zero clears");
    @(negedge clk); irq_set = 1; @(negedge clk); irq_set = 0;
    wr(4'hD, 4'h1, 0, 1); rd(4'hD, 4'h5, "R9 set wins over same-edge clear");
    // R12 reset clears control state
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(4'hF, 0, "R12 F after reset"); rd(4'hE, 0, "R12 E after reset");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule